// File: doc/BRIEF.md
# Multiphase Core Supply Start-Up Sequencer

This block is the digital control that brings up a multiphase buck converter for a processor core. It waits until the supply is enabled and the input rail is above its lockout level. It then runs three timed intervals on an external delay ramp, with two soft-start phases placed between them. The first soft start ramps the output to a fixed boot level of 1.1 V. The hold interval that follows lets the processor's voltage-identification code settle. The second soft start moves the output up or down to the level that code selects. Power-good is reported only after a final blanking interval.

The analog parts stay outside the block and appear to it as single-bit flags: the ramp comparator, the soft-start ramp, the DAC and the masking timer. The block drives back a run/reset level for the delay ramp and an enable and target select for soft start. It also drives a blanking level for the PWM outputs, a strobe that marks the window in which unused phases are detected, and power-good. The sequencer state is brought out as a 3-bit code so that test equipment can observe it.

Top module: `vr_startup_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `pwm_blank_o` is 1, and `ramp_run_o`, `pdet_win_o`, `ss_en_o`, `ss_tgt_vid_o` and `pgood_o` are all 0.
- R2: The sequencer stays in idle while `en_i` and `uvlo_ok_i` are not both 1. At the first clock edge where both are 1, it enters the pre-start delay state (code 1).
- R3: Each delay state has a code: pre-start delay is 1, boot hold is 3 and power-good blanking is 5. In the first clock of a delay state, `ramp_run_o` is 0 and the external ramp restarts. From the next clock on, `ramp_run_o` is 1. `ramp_hit_i` moves the sequencer on at the next edge only when `ramp_run_o` is 1; at any other time it is ignored.
- R4: The first soft-start state (code 2) is entered from the pre-start delay. In its first PDET_CYCLES clocks (default 4), `pwm_blank_o` and `pdet_win_o` are 1, `ss_en_o` is 0, and `ss_done_i` is ignored. After that window, `pwm_blank_o` and `pdet_win_o` are 0 and `ss_en_o` is 1.
- R5: `ss_tgt_vid_o` is 0 (boot level, 1.1 V) in states 2 and 3. It is 1 (code-selected level) in states 4, 5 and 6.
- R6: When `ss_done_i` is 1 after the detection window in state 2, the sequencer enters boot hold (3). A ramp hit in boot hold moves it to the second soft start (code 4). `ss_en_o` stays 1 in states 3 through 6.
- R7: State 4 moves to power-good blanking (5) only when `ss_done_i` and `vid_mask_done_i` are both 1, and not in the first clock of state 4. Either flag alone keeps the sequencer in state 4.
- R8: A ramp hit in power-good blanking moves the sequencer to ready (code 6). `pgood_o` is 1 only in ready, and ready holds while `en_i` and `uvlo_ok_i` stay 1.
- R9: If `en_i` or `uvlo_ok_i` is 0 at a clock edge, the sequencer is in idle after that edge, whatever state it was in. All outputs then take their R1 values.
- R10: `pdet_win_o` is never 1 outside state 2. `pwm_blank_o` is 1 in states 0 and 1 and during the detection window, and 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Supply enable |
| uvlo_ok_i | input | 1 | Input rail above undervoltage lockout |
| ramp_hit_i | input | 1 | Delay ramp has reached its threshold |
| ss_done_i | input | 1 | Soft-start ramp has reached its target |
| vid_mask_done_i | input | 1 | Masking interval after a code change has expired |
| ramp_run_o | output | 1 | 1 lets the delay ramp charge, 0 holds it at zero |
| pwm_blank_o | output | 1 | Forces all PWM outputs low |
| pdet_win_o | output | 1 | Phase-detection window strobe |
| ss_tgt_vid_o | output | 1 | Soft-start target: 0 boot level, 1 code level |
| ss_en_o | output | 1 | Soft-start ramp enable |
| pgood_o | output | 1 | Power good |
| state_o | output | 3 | Encoded sequencer state |

## Verification
The hardest case to reach from the ports is a completion flag that arrives at a moment when it must be ignored. Examples are a ramp hit in the clock where the ramp is being restarted, `ss_done_i` inside the detection window, and both soft-start flags in the first clock of the second soft start. The stimulus drives the sequencer to each of those exact clocks and holds the flag high there. It then checks that the state code has not moved and moves only at the next legal clock. A second run drops the enable in the middle of the sequence to check the return to idle.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_DLY   = 3'd1,
      ST_SSB   = 3'd2,
      ST_HOLD  = 3'd3,
      ST_SSV   = 3'd4,
      ST_BLANK = 3'd5,
      ST_READY = 3'd6
   } vrs_state_e;

   function automatic logic is_ramp_state(vrs_state_e s);
      return (s == ST_DLY) || (s == ST_HOLD) || (s == ST_BLANK);
   endfunction

endpackage

// File: rtl/vrs_pdet_timer.sv
module vrs_pdet_timer
   import vrs_pkg::*;
#(
   parameter int PDET_CYCLES = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  vrs_state_e state,
   output logic       win
);
   localparam int CNT_W = $clog2(PDET_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PDET_CYCLES);

   generate
      if (PDET_CYCLES < 1) begin : g_bad_cycles
         $error("PDET_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (state != ST_SSB)
         cnt_q <= '0;
      else if (cnt_q < CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

   assign win = (state == ST_SSB) && (cnt_q < CNT_MAX);

   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);
   assert_win_place_R10: assert property (@(posedge clk) disable iff (!rst_n)
      win |-> state == ST_SSB);
   assert_win_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SSB && $past(state) == ST_DLY) |-> win);
endmodule

// File: rtl/vrs_fsm.sv
module vrs_fsm
   import vrs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       ramp_hit,
   input  logic       win,
   input  logic       ss_done,
   input  logic       mask_done,
   output vrs_state_e state,
   output logic       fresh
);
   vrs_state_e state_q, state_d;
   logic       fresh_q;
   logic       ramp_live;

   assign ramp_live = is_ramp_state(state_q) && !fresh_q;

   always_comb begin
      state_d = state_q;
      if (!go) begin
         state_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:  state_d = ST_DLY;
            ST_DLY:   if (ramp_live && ramp_hit) state_d = ST_SSB;
            ST_SSB:   if (!win && ss_done) state_d = ST_HOLD;
            ST_HOLD:  if (ramp_live && ramp_hit) state_d = ST_SSV;
            ST_SSV:   if (!fresh_q && ss_done && mask_done) state_d = ST_BLANK;
            ST_BLANK: if (ramp_live && ramp_hit) state_d = ST_READY;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fresh_q <= 1'b0;
      end else begin
         state_q <= state_d;
         fresh_q <= (state_d != state_q);
      end
   end

   assign state = state_q;
   assign fresh = fresh_q;

   assert_idle_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !go) |=> state_q == ST_IDLE);
   assert_loss_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> state_q == ST_IDLE);
   assert_vid_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SSV && go) |=> (state_q == ST_BLANK) == $past(!fresh_q && ss_done && mask_done));
   assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READY && go) |=> state_q == ST_READY);
endmodule

// File: rtl/vrs_out_decode.sv
module vrs_out_decode
   import vrs_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  vrs_state_e state,
   input  logic       fresh,
   input  logic       win,
   output logic       ramp_run,
   output logic       pwm_blank,
   output logic       pdet_win,
   output logic       tgt_vid,
   output logic       ss_en,
   output logic       pgood
);
   logic [5:0] dec;

   always_comb begin
      dec[0] = is_ramp_state(state) && !fresh;
      dec[1] = (state == ST_IDLE) || (state == ST_DLY) || win;
      dec[2] = win;
      dec[3] = (state == ST_SSV) || (state == ST_BLANK) || (state == ST_READY);
      dec[4] = ((state == ST_SSB) && !win) || (state == ST_HOLD) || dec[3];
      dec[5] = (state == ST_READY);
   end

   logic [5:0] out_v;

   generate
      if (REG_OUT) begin : g_reg
         logic [5:0] out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 6'b000010;
            else        out_q <= dec;
         end
         assign out_v = out_q;
      end else begin : g_comb
         assign out_v = dec;
      end
   endgenerate

   assign ramp_run  = out_v[0];
   assign pwm_blank = out_v[1];
   assign pdet_win  = out_v[2];
   assign tgt_vid   = out_v[3];
   assign ss_en     = out_v[4];
   assign pgood     = out_v[5];

   if (!REG_OUT) begin : g_chk
      assert_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (fresh && is_ramp_state(state)) |-> !ramp_run);
      assert_pgood_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pgood) |-> $past(state) == ST_BLANK);
      assert_blank_win_R4: assert property (@(posedge clk) disable iff (!rst_n)
         pdet_win |-> (pwm_blank && !ss_en));
   end
endmodule

// File: rtl/vr_startup_seq.sv
module vr_startup_seq
   import vrs_pkg::*;
#(
   parameter int PDET_CYCLES = 4,
   parameter bit REG_OUT     = 1'b0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       uvlo_ok_i,
   input  logic       ramp_hit_i,
   input  logic       ss_done_i,
   input  logic       vid_mask_done_i,
   output logic       ramp_run_o,
   output logic       pwm_blank_o,
   output logic       pdet_win_o,
   output logic       ss_tgt_vid_o,
   output logic       ss_en_o,
   output logic       pgood_o,
   output logic [2:0] state_o
);
   vrs_state_e state;
   logic       fresh;
   logic       win;
   logic       go;

   assign go = en_i && uvlo_ok_i;

   vrs_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .ramp_hit  (ramp_hit_i),
      .win       (win),
      .ss_done   (ss_done_i),
      .mask_done (vid_mask_done_i),
      .state     (state),
      .fresh     (fresh)
   );

   vrs_pdet_timer #(.PDET_CYCLES(PDET_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state),
      .win   (win)
   );

   vrs_out_decode #(.REG_OUT(REG_OUT)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .fresh     (fresh),
      .win       (win),
      .ramp_run  (ramp_run_o),
      .pwm_blank (pwm_blank_o),
      .pdet_win  (pdet_win_o),
      .tgt_vid   (ss_tgt_vid_o),
      .ss_en     (ss_en_o),
      .pgood     (pgood_o)
   );

   assign state_o = state;

   assert_hold_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && $past(state) == ST_SSB) |-> $past(ss_done_i && !win));
endmodule

// File: tb/tb_vr_startup_seq.sv
module tb_vr_startup_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 0, uvlo_ok_i = 0, ramp_hit_i = 0, ss_done_i = 0, vid_mask_done_i = 0;
   logic ramp_run_o, pwm_blank_o, pdet_win_o, ss_tgt_vid_o, ss_en_o, pgood_o;
   logic [2:0] state_o;

   always #2.5 clk = ~clk;

   vr_startup_seq dut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_ok_i(uvlo_ok_i),
      .ramp_hit_i(ramp_hit_i), .ss_done_i(ss_done_i), .vid_mask_done_i(vid_mask_done_i),
      .ramp_run_o(ramp_run_o), .pwm_blank_o(pwm_blank_o), .pdet_win_o(pdet_win_o),
      .ss_tgt_vid_o(ss_tgt_vid_o), .ss_en_o(ss_en_o), .pgood_o(pgood_o), .state_o(state_o)
   );

   typedef struct {
      logic [2:0] st;
      logic       ramp;
      logic       win;
      string      tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Expected output vector {ramp,blank,win,tgt,ss_en,pgood} derived from R1..R10
   function automatic logic [5:0] expect_vec(exp_t e);
      logic blank, tgt, ssen, pg;
      blank = (e.st == 3'd0) || (e.st == 3'd1) || e.win;
      tgt   = (e.st >= 3'd4);
      ssen  = ((e.st == 3'd2) && !e.win) || (e.st >= 3'd3);
      pg    = (e.st == 3'd6);
      return {e.ramp, blank, e.win, tgt, ssen, pg};
   endfunction

   task automatic compare(exp_t e);
      logic [5:0] act, exv;
      act = {ramp_run_o, pwm_blank_o, pdet_win_o, ss_tgt_vid_o, ss_en_o, pgood_o};
      exv = expect_vec(e);
      checks++;
      if (state_o !== e.st || act !== exv) begin
         fails++;
         $display("FAIL %s: state=%0d outs=%b expected state=%0d outs=%b",
                  e.tag, state_o, act, e.st, exv);
      end
   endtask

   // monitor: pops one expected item per cycle, sampled at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) compare(q.pop_front());
      end
   end

   // driver: apply inputs, clock once, push expected post-edge result
   task automatic step(input logic en, input logic uv, input logic hit,
                       input logic ssd, input logic msk,
                       input logic [2:0] st, input logic ramp, input logic win,
                       input string tag);
      exp_t e;
      @(negedge clk);
      en_i = en; uvlo_ok_i = uv; ramp_hit_i = hit; ss_done_i = ssd; vid_mask_done_i = msk;
      @(posedge clk);
      #1;
      e.st = st; e.ramp = ramp; e.win = win; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int wd = 0;
      while (!done && wd < 5000) begin
         @(posedge clk);
         wd++;
      end
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      exp_t r;
      repeat (3) @(negedge clk);
      r.st = 0; r.ramp = 0; r.win = 0; r.tag = "R1 reset state";
      compare(r);
      @(negedge clk);
      rst_n = 1'b1;

      // full sequence
      step(0,1,0,0,0, 3'd0,0,0, "R2 idle without enable");
      step(1,0,0,0,0, 3'd0,0,0, "R2 idle without uvlo ok");
      step(1,1,0,0,0, 3'd1,0,0, "R2 enter delay, R3 rearm clock");
      step(1,1,1,0,0, 3'd1,1,0, "R3 hit ignored during rearm");
      step(1,1,1,0,0, 3'd2,0,1, "R3 hit ends delay, R4 window starts");
      step(1,1,0,1,0, 3'd2,0,1, "R4 ss_done ignored in window c2");
      step(1,1,0,1,0, 3'd2,0,1, "R4 window c3");
      step(1,1,0,1,0, 3'd2,0,1, "R4 window c4");
      step(1,1,0,0,0, 3'd2,0,0, "R4 window over, soft start on");
      step(1,1,0,0,0, 3'd2,0,0, "R5 boot target in first soft start");
      step(1,1,0,1,0, 3'd3,0,0, "R6 enter boot hold, R3 rearm");
      step(1,1,1,0,0, 3'd3,1,0, "R3 hold hit ignored during rearm");
      step(1,1,0,0,0, 3'd3,1,0, "R6 hold waits for ramp");
      step(1,1,1,0,0, 3'd4,0,0, "R6 hold ends, R5 vid target");
      step(1,1,0,1,1, 3'd4,0,0, "R7 flags ignored in first clock");
      step(1,1,0,1,0, 3'd4,0,0, "R7 soft start done alone");
      step(1,1,0,0,1, 3'd4,0,0, "R7 mask done alone");
      step(1,1,0,1,1, 3'd5,0,0, "R7 both flags, R3 rearm");
      step(1,1,1,0,0, 3'd5,1,0, "R3 blank hit ignored during rearm");
      step(1,1,0,0,0, 3'd5,1,0, "R8 no pgood before blank ends");
      step(1,1,1,0,0, 3'd6,0,0, "R8 ready with pgood");
      step(1,1,1,1,1, 3'd6,0,0, "R8 ready holds");
      step(1,0,0,0,0, 3'd0,0,0, "R9 uvlo loss from ready");
      step(1,1,0,0,0, 3'd1,0,0, "R2 restart after loss");

      // drop enable during the detection window
      step(1,1,0,0,0, 3'd1,1,0, "R3 ramp running");
      step(1,1,1,0,0, 3'd2,0,1, "R10 window in state 2");
      step(1,1,0,0,0, 3'd2,0,1, "R10 window second clock");
      step(0,1,0,0,0, 3'd0,0,0, "R9 enable loss in window");

      // drop enable in boot hold
      step(1,1,0,0,0, 3'd1,0,0, "R2 reenter delay");
      step(1,1,1,0,0, 3'd1,1,0, "R3 rearm ignore again");
      step(1,1,1,0,0, 3'd2,0,1, "R4 window restart");
      repeat (3) step(1,1,0,0,0, 3'd2,0,1, "R4 window held");
      step(1,1,0,1,0, 3'd2,0,0, "R4 ss_done at window end ignored");
      step(1,1,0,1,0, 3'd3,0,0, "R6 hold entered");
      step(0,0,1,0,0, 3'd0,0,0, "R9 both lost in hold");
      step(0,0,0,0,0, 3'd0,0,0, "R1 idle outputs after loss");

      drain();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule